// File: doc/BRIEF.md
# Byte-Serial 16-Bit Register-Pair Adder

This block adds or subtracts a 16-bit register pair to or from a 16-bit accumulator pair. The operation is add, add-with-carry or subtract-with-carry. It reuses a single 8-bit arithmetic unit over two passes. The low byte goes first. Its carry or borrow then feeds the high byte. Fixed wait cycles come before each pass, so the block matches the cycle count of a byte-wide datapath.

The block decodes the instruction byte itself. A second input says whether the extended-page prefix came before that byte. The decoded opcode picks the operation and the operand pair. The operand pair is one of BC, DE, the accumulator pair itself (HL), or SP. A start strobe launches one operation. A one-cycle done pulse reports that the 16-bit result and the new flags are ready on the outputs. The outputs hold their values until the next operation finishes.

Top module: `pair_adder16`

## Requirements
- R1: After reset, `result_o` is 0x0000, `flags_o` is 0x00 and `done_o` is low.
- R2: Without the prefix, opcodes 0x09, 0x19, 0x29 and 0x39 select ADD. The operand is BC, DE, HL or SP in that order, taken from opcode bits 5:4. HL means `acc_i` itself.
- R3: With the prefix, 0x4A, 0x5A, 0x6A and 0x7A select ADC, and 0x42, 0x52, 0x62 and 0x72 select SBC. In both cases opcode bits 5:4 pick BC, DE, HL or SP in that order.
- R4: A start with any other opcode/prefix combination is ignored. No done pulse follows, and the outputs keep their values.
- R5: An accepted start gives exactly one `done_o` pulse, one cycle wide, on the 10th rising edge after the accepting edge. That count is 4 wait cycles, the low pass, 3 wait cycles, the high pass, and one more cycle before done.
- R6: The flag byte layout is S=bit7, Z=6, Y=5, H=4, X=3, P/V=2, N=1, C=0. ADD computes acc+opd modulo 2^16 with no carry in. ADD sets C to the carry out of bit 15 and H to the carry out of bit 11, with Y=result bit 13, X=result bit 11 and N=0. S, Z and P/V keep their incoming values.
- R7: ADC computes acc+opd+C. C and H are as in ADD. S is result bit 15, V is signed 16-bit overflow, N=0, and Y/X are result bits 13/11.
- R8: SBC computes acc-opd-C. C is the borrow out of bit 15, H is the borrow out of bit 11, V is signed overflow, N=1, and S/Y/X are as in ADC.
- R9: The low-byte carry or borrow propagates into the high byte. For ADC and SBC, Z is set only when all 16 result bits are zero.
- R10: A start that arrives while an operation is in progress is ignored. The running operation finishes with its own operands and gives a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, sampled when idle |
| ext_i | input | 1 | High when the opcode follows the extended-page prefix |
| opcode_i | input | 8 | Instruction byte to decode |
| acc_i | input | 16 | Accumulator pair (HL) |
| bc_i | input | 16 | BC pair |
| de_i | input | 16 | DE pair |
| sp_i | input | 16 | Stack pointer |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 16 | New accumulator pair value |
| flags_o | output | 8 | New flag byte |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The vector table covers all twelve opcodes, so each operand pair is reached under every operation.

- **Carry into the low byte.** An ADD with the incoming carry set shows that ADD ignores it, while ADC/SBC pairs show that they use it.
- **Carry between the bytes.** Operands such as 0x00FF+1 and 0x0100-0-1 tell a carry or borrow that crosses bytes apart from one that stays in the low byte.
- **Flag corners.** The 0x7FFF+0+1 and 0x8000-1 cases tell signed overflow apart from unsigned carry. Bit-11 boundaries separate H from C.
- **Z over the whole word.** Results whose low byte is zero but whose high byte is not show that Z is judged on all 16 bits.
- **Directed tests.** Undecodable opcodes and a second start during a busy window check that such strobes leave the outputs and the done count unchanged.

// File: rtl/pair_add_pkg.sv
package pair_add_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_ADC = 2'd1, OP_SBC = 2'd2} op_e;

  // flag byte positions
  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_X  = 3;
  localparam int FB_H  = 4;
  localparam int FB_Y  = 5;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;
endpackage

// File: rtl/pa_decode.sv
module pa_decode
  import pair_add_pkg::*;
(
  input  logic       ext_i,
  input  logic [7:0] opcode_i,
  output logic       valid_o,
  output op_e        op_o,
  output logic [1:0] sel_o
);
  always_comb begin
    valid_o = 1'b0;
    op_o    = OP_ADD;
    sel_o   = opcode_i[5:4];
    if (!ext_i && opcode_i[7:6] == 2'b00 && opcode_i[3:0] == 4'h9) begin
      valid_o = 1'b1;
      op_o    = OP_ADD;
    end else if (ext_i && opcode_i[7:6] == 2'b01 && opcode_i[3:0] == 4'hA) begin
      valid_o = 1'b1;
      op_o    = OP_ADC;
    end else if (ext_i && opcode_i[7:6] == 2'b01 && opcode_i[3:0] == 4'h2) begin
      valid_o = 1'b1;
      op_o    = OP_SBC;
    end
  end
endmodule

// File: rtl/pa_byte_alu.sv
module pa_byte_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,   // carry in, or borrow in when sub_i
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,  // carry out, or borrow out when sub_i
  output logic         half_o,  // carry/borrow out of the lower half
  output logic         ovf_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  bx;
  logic          cx;
  logic [W:0]    full;
  logic [HW:0]   half;

  // subtraction as a + ~b + ~borrow
  assign bx   = b_i ^ {W{sub_i}};
  assign cx   = cin_i ^ sub_i;
  assign full = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cx};
  assign half = {1'b0, a_i[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cx};

  assign res_o  = full[W-1:0];
  assign cout_o = full[W] ^ sub_i;
  assign half_o = half[HW] ^ sub_i;
  assign ovf_o  = (a_i[W-1] == bx[W-1]) && (res_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/pair_adder16.sv
module pair_adder16
  import pair_add_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int LO_WAIT = 4,
  parameter int HI_WAIT = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                ext_i,
  input  logic [7:0]          opcode_i,
  input  logic [2*BYTE_W-1:0] acc_i,
  input  logic [2*BYTE_W-1:0] bc_i,
  input  logic [2*BYTE_W-1:0] de_i,
  input  logic [2*BYTE_W-1:0] sp_i,
  input  logic [7:0]          flags_i,
  output logic [2*BYTE_W-1:0] result_o,
  output logic [7:0]          flags_o,
  output logic                done_o
);
  localparam int DW    = 2 * BYTE_W;
  localparam int MAXW  = (LO_WAIT > HI_WAIT) ? LO_WAIT : HI_WAIT;
  localparam int CNT_W = (MAXW > 1) ? $clog2(MAXW) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_LO, S_WHI, S_HI, S_DONE} st_e;

  st_e               state;
  logic [CNT_W-1:0]  cnt;
  logic [DW-1:0]     acc_q, opd_q;
  op_e               op_q;
  logic              cin_q;
  logic [7:0]        fin_q;
  logic [BYTE_W-1:0] lo_res_q;
  logic              lo_c_q;
  logic [DW-1:0]     result_q;
  logic [7:0]        flags_q;
  logic              done_q;

  logic              dec_valid;
  op_e               dec_op;
  logic [1:0]        dec_sel;
  logic [DW-1:0]     opd_mux;

  pa_decode u_dec (
    .ext_i   (ext_i),
    .opcode_i(opcode_i),
    .valid_o (dec_valid),
    .op_o    (dec_op),
    .sel_o   (dec_sel)
  );

  always_comb begin
    case (dec_sel)
      2'd0:    opd_mux = bc_i;
      2'd1:    opd_mux = de_i;
      2'd2:    opd_mux = acc_i;
      default: opd_mux = sp_i;
    endcase
  end

  // one shared byte ALU, steered by pass
  logic              hi_pass;
  logic [BYTE_W-1:0] alu_a, alu_b, alu_res;
  logic              alu_cin, alu_cout, alu_half, alu_ovf;

  assign hi_pass = (state == S_HI);
  assign alu_a   = hi_pass ? acc_q[DW-1:BYTE_W] : acc_q[BYTE_W-1:0];
  assign alu_b   = hi_pass ? opd_q[DW-1:BYTE_W] : opd_q[BYTE_W-1:0];
  assign alu_cin = hi_pass ? lo_c_q : cin_q;

  pa_byte_alu #(.W(BYTE_W)) u_alu (
    .a_i   (alu_a),
    .b_i   (alu_b),
    .cin_i (alu_cin),
    .sub_i (op_q == OP_SBC),
    .res_o (alu_res),
    .cout_o(alu_cout),
    .half_o(alu_half),
    .ovf_o (alu_ovf)
  );

  logic [7:0] flags_new;
  always_comb begin
    flags_new        = fin_q;
    flags_new[FB_C]  = alu_cout;
    flags_new[FB_H]  = alu_half;
    flags_new[FB_X]  = alu_res[3];
    flags_new[FB_Y]  = alu_res[5];
    flags_new[FB_N]  = (op_q == OP_SBC);
    if (op_q != OP_ADD) begin
      flags_new[FB_S]  = alu_res[BYTE_W-1];
      flags_new[FB_Z]  = (alu_res == '0) && (lo_res_q == '0);
      flags_new[FB_PV] = alu_ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= S_IDLE;
      cnt      <= '0;
      acc_q    <= '0;
      opd_q    <= '0;
      op_q     <= OP_ADD;
      cin_q    <= 1'b0;
      fin_q    <= '0;
      lo_res_q <= '0;
      lo_c_q   <= 1'b0;
      result_q <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state == S_DONE);
      case (state)
        S_IDLE: if (start_i && dec_valid) begin
          acc_q <= acc_i;
          opd_q <= opd_mux;
          op_q  <= dec_op;
          cin_q <= (dec_op != OP_ADD) && flags_i[FB_C];
          fin_q <= flags_i;
          cnt   <= '0;
          state <= S_WLO;
        end
        S_WLO: if (cnt == CNT_W'(LO_WAIT - 1)) begin
          cnt   <= '0;
          state <= S_LO;
        end else cnt <= cnt + 1'b1;
        S_LO: begin
          lo_res_q <= alu_res;
          lo_c_q   <= alu_cout;
          state    <= S_WHI;
        end
        S_WHI: if (cnt == CNT_W'(HI_WAIT - 1)) begin
          cnt   <= '0;
          state <= S_HI;
        end else cnt <= cnt + 1'b1;
        S_HI: begin
          result_q <= {alu_res, lo_res_q};
          flags_q  <= flags_new;
          state    <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;
  assign done_o   = done_q;

  // R5: done exactly one cycle after the high-byte latch, single-cycle wide
  a_r5_done_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_HI) |=> ##1 done_o);
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10: captured operands stay put while busy
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != S_IDLE) |=> ($stable(acc_q) && $stable(opd_q) && $stable(op_q)));
  // R6: ADD keeps S, Z, P/V
  a_r6_add_keeps_szp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_ADD) |-> (flags_o[FB_S] == fin_q[FB_S] &&
      flags_o[FB_Z] == fin_q[FB_Z] && flags_o[FB_PV] == fin_q[FB_PV]));
  // R9: Z judged over the whole 16-bit result for ADC/SBC
  a_r9_zero_full_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q != OP_ADD) |-> (flags_o[FB_Z] == (result_o == '0)));
  // R8: N reflects subtraction on completion
  a_r8_n_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (flags_o[FB_N] == (op_q == OP_SBC)));
endmodule

// File: tb/tb_pair_adder16.sv
module tb_pair_adder16;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        ext_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic [15:0] acc_i = '0, bc_i = '0, de_i = '0, sp_i = '0;
  logic [7:0]  flags_i = '0;
  logic [15:0] result_o;
  logic [7:0]  flags_o;
  logic        done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pair_adder16 dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ext_i(ext_i),
    .opcode_i(opcode_i), .acc_i(acc_i), .bc_i(bc_i), .de_i(de_i), .sp_i(sp_i),
    .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .done_o(done_o)
  );

  // {ext, opcode, acc, bc, de, sp, flags_in}
  localparam logic [80:0] VECS [NV] = '{
    {1'b0, 8'h09, 16'h1234, 16'h1111, 16'h0000, 16'h0000, 8'hC5},
    {1'b0, 8'h19, 16'h00FF, 16'h0000, 16'h0001, 16'h0000, 8'h00},
    {1'b0, 8'h29, 16'h8800, 16'h0000, 16'h0000, 16'h0000, 8'h00},
    {1'b0, 8'h39, 16'h0FFF, 16'h0000, 16'h0000, 16'h0001, 8'h01},
    {1'b1, 8'h4A, 16'h7FFF, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h5A, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h6A, 16'h0080, 16'h0000, 16'h0000, 16'h0000, 8'h40},
    {1'b1, 8'h7A, 16'h1000, 16'h0000, 16'h0000, 16'h2000, 8'h01},
    {1'b1, 8'h42, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 8'h00},
    {1'b1, 8'h52, 16'h0100, 16'h0000, 16'h0100, 16'h0000, 8'h00},
    {1'b1, 8'h62, 16'h5555, 16'h0000, 16'h0000, 16'h0000, 8'h01},
    {1'b1, 8'h72, 16'h8000, 16'h0000, 16'h0000, 16'h0001, 8'h00},
    {1'b1, 8'h42, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 8'h01}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // reference model written from R2/R3/R6/R7/R8
  task automatic model(input logic ext, input logic [7:0] opc,
                       input logic [15:0] a, input logic [15:0] bc,
                       input logic [15:0] de, input logic [15:0] sp,
                       input logic [7:0] fin,
                       output logic [15:0] r, output logic [7:0] f,
                       output string req);
    logic [15:0] b;
    logic [16:0] w;
    logic [12:0] h;
    logic        c;
    case (opc[5:4])
      2'd0: b = bc;
      2'd1: b = de;
      2'd2: b = a;
      default: b = sp;
    endcase
    c = fin[0];
    f = fin;
    if (!ext) begin
      req = "R6";
      w = {1'b0, a} + {1'b0, b};
      h = {1'b0, a[11:0]} + {1'b0, b[11:0]};
      r = w[15:0];
      f[1] = 1'b0;
    end else if (opc[3:0] == 4'hA) begin
      req = "R7";
      w = {1'b0, a} + {1'b0, b} + {16'd0, c};
      h = {1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'd0, c};
      r = w[15:0];
      f[1] = 1'b0;
      f[2] = (a[15] == b[15]) && (r[15] != a[15]);
    end else begin
      req = "R8";
      w = {1'b0, a} - {1'b0, b} - {16'd0, c};
      h = {1'b0, a[11:0]} - {1'b0, b[11:0]} - {12'd0, c};
      r = w[15:0];
      f[1] = 1'b1;
      f[2] = (a[15] != b[15]) && (r[15] != a[15]);
    end
    f[0] = w[16];
    f[4] = h[12];
    f[3] = r[11];
    f[5] = r[13];
    if (ext) begin
      f[7] = r[15];
      f[6] = (r == 16'h0000);
    end
  endtask

  // launch one operation; optionally fire a second start while busy
  task automatic run(input logic [80:0] v, input bit inject,
                     output int first, output int ndone,
                     output logic [15:0] r, output logic [7:0] f);
    first = 0; ndone = 0; r = '0; f = '0;
    @(negedge clk_i);
    {ext_i, opcode_i, acc_i, bc_i, de_i, sp_i, flags_i} = v;
    start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 1; i <= 24; i++) begin
      if (inject && i == 3) begin
        ext_i = 1'b0; opcode_i = 8'h09; acc_i = 16'hAAAA; bc_i = 16'h1111;
        start_i = 1'b1;
      end else start_i = 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      if (done_o) begin
        ndone++;
        if (first == 0) begin
          first = i; r = result_o; f = flags_o;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] er, ar, keep_r;
    logic [7:0]  ef, af, keep_f;
    string       rq;
    int          first, nd;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk(result_o == 16'h0000, "R1", "result", result_o, 0);
    chk(flags_o == 8'h00, "R1", "flags", flags_o, 0);
    chk(done_o == 1'b0, "R1", "done", done_o, 0);
    rst_ni = 1'b1;

    // table walk: R2, R3, R5-R9
    for (int k = 0; k < NV; k++) begin
      model(VECS[k][80], VECS[k][79:72], VECS[k][71:56], VECS[k][55:40],
            VECS[k][39:24], VECS[k][23:8], VECS[k][7:0], er, ef, rq);
      run(VECS[k], 1'b0, first, nd, ar, af);
      chk(first == 10, "R5", "done latency", first, 10);
      chk(nd == 1, "R5", "done count", nd, 1);
      chk(ar == er, VECS[k][80] ? "R3" : "R2", "result", ar, er);
      chk(af == ef, rq, "flags", af, ef);
    end

    // R9 borrow crossing bytes and Z over full word (vector 12: 0x0100-0-1)
    run(VECS[12], 1'b0, first, nd, ar, af);
    chk(ar == 16'h00FF, "R9", "cross-byte borrow", ar, 16'h00FF);
    chk(af[6] == 1'b0, "R9", "Z with zero high byte only", af[6], 0);

    // R4 undecodable combinations ignored
    keep_r = result_o; keep_f = flags_o;
    run({1'b1, 8'h09, 16'h1234, 16'h4321, 16'h0, 16'h0, 8'h00}, 1'b0, first, nd, ar, af);
    chk(nd == 0, "R4", "done after ext+0x09", nd, 0);
    run({1'b0, 8'h4A, 16'h1234, 16'h4321, 16'h0, 16'h0, 8'h00}, 1'b0, first, nd, ar, af);
    chk(nd == 0, "R4", "done after 0x4A no prefix", nd, 0);
    run({1'b1, 8'h4B, 16'h1234, 16'h4321, 16'h0, 16'h0, 8'h00}, 1'b0, first, nd, ar, af);
    chk(nd == 0, "R4", "done after ext+0x4B", nd, 0);
    chk(result_o == keep_r, "R4", "result held", result_o, keep_r);
    chk(flags_o == keep_f, "R4", "flags held", flags_o, keep_f);

    // R10 start during busy ignored
    model(VECS[7][80], VECS[7][79:72], VECS[7][71:56], VECS[7][55:40],
          VECS[7][39:24], VECS[7][23:8], VECS[7][7:0], er, ef, rq);
    run(VECS[7], 1'b1, first, nd, ar, af);
    chk(nd == 1, "R10", "single done", nd, 1);
    chk(first == 10, "R10", "latency unchanged", first, 10);
    chk(ar == er, "R10", "result of first op", ar, er);
    chk(result_o == er, "R10", "result still held", result_o, er);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule